// File: doc/BRIEF.md
# Window-One Data Link Sequencer

This block runs the numbered-frame side of a balanced link-layer protocol in the LAPB/LAPD family, with only one frame allowed in flight each way. Upstream logic has already stripped flags, checked the FCS and matched the address. It presents each frame's control field together with a flag saying whether an information field followed. The block keeps the send and receive state variables and decides whether each information (I) frame is taken or dropped. It asks the transmitter for supervisory replies and polls, follows the busy state of the far end, and runs a retry timer.

Unnumbered frames are not sequenced. They are flagged for the receive buffer and passed to software. The CPU sees interrupts only for a change in far-end busy state, for protocol errors and for a link failure. Software can mark the local station busy at any time, and a reset command returns the link to its starting state.

Every response and strobe appears one clock after the frame or event that caused it. The control field is a single octet in normal mode (counters modulo 8) or two octets in extended mode (counters modulo 128). Whatever the mode, sequence comparisons look only at bit 0 of each counter.

Top module: `lapb_w1_seq`

## Requirements
- R1: Normal mode (cfg_ext=0) keeps V(S) and V(R) modulo 8 and decodes one octet: bit0=0 marks I with N(S) in bits 3:1, P/F in bit 4 and N(R) in bits 7:5. Bits1:0=01 mark S with the type in bits 3:2 (00 RR, 01 RNR, 10 REJ, 11 invalid). Bits1:0=11 mark U. Extended mode (cfg_ext=1) counts modulo 128 and places N(S) (I) in bits 7:1, P/F in bit 8 and N(R) in bits 15:9.
- R2: An I-frame is in sequence when bit 0 of N(S) equals bit 0 of V(R). The higher bits are never compared.
- R3: An in-sequence I-frame with the station not locally busy pulses rx_i_accept and increments V(R). It requests an RR response (tx_s_cmd=0) carrying the new V(R) and with F equal to the frame's P bit.
- R4: An out-of-sequence I-frame is dropped. There is no rx_i_accept, V(R) does not change, and an RR response carrying the current V(R) is requested.
- R5: While cpu_rnr is high, every I-frame is dropped and an RNR response (type 01) carrying the current V(R) is requested.
- R6: A valid S-frame triggers no response. RNR sets remote_busy, and RR or REJ clears it. irq_remote_busy or irq_remote_ready pulses only when remote_busy changes.
- R7: irq_proto_err pulses for an S-frame with an information field, for an S-frame of type 11, and for an N(R) whose bit 0 differs from V(S) bit 0 while no I-frame is unacknowledged.
- R8: A U-frame pulses rx_u_fwd and produces no response and no change of state.
- R9: While remote_busy is high and nothing is unacknowledged, every cfg_t1 cycles without a received frame the block sends an RR command poll (cmd=1, P=1) with V(R). It keeps doing so without limit.
- R10: tx_i_sent, when nothing is unacknowledged, increments V(S) and sets ack_pending. A received N(R) whose bit 0 equals V(S) bit 0 clears ack_pending.
- R11: While ack_pending is set, each cfg_t1 expiry sends an RR command poll, up to cfg_n2 polls. The next expiry sets irq_link_fail instead, after which no further polls are sent. irq_link_fail stays high until cpu_reset.
- R12: A cpu_reset pulse clears V(S), V(R), ack_pending, remote_busy, the retry count and irq_link_fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ext | input | 1 | 1 selects the two-octet, modulo-128 control field |
| cfg_t1 | input | 16 | Retry timer period in cycles (at least 1) |
| cfg_n2 | input | 4 | Maximum number of polls while unacknowledged |
| cpu_rnr | input | 1 | Local station busy |
| cpu_reset | input | 1 | Link reset command pulse |
| rx_valid | input | 1 | Received frame strobe |
| rx_ctrl | input | 16 | Received control field |
| rx_info | input | 1 | Received frame carried an information field |
| tx_i_sent | input | 1 | An I-frame with N(S)=V(S) was transmitted |
| tx_s_req | output | 1 | Supervisory frame request pulse |
| tx_s_type | output | 2 | Supervisory type (00 RR, 01 RNR, 10 REJ) |
| tx_s_nr | output | 7 | N(R) for the supervisory frame |
| tx_s_cmd | output | 1 | 1 command, 0 response |
| tx_s_pf | output | 1 | P/F bit of the supervisory frame |
| rx_i_accept | output | 1 | I-frame accepted into the receive buffer |
| rx_u_fwd | output | 1 | U-frame forwarded to the receive buffer |
| irq_remote_busy | output | 1 | Far end became busy |
| irq_remote_ready | output | 1 | Far end became ready |
| irq_proto_err | output | 1 | Protocol error |
| irq_link_fail | output | 1 | Retries exhausted (sticky) |
| remote_busy | output | 1 | Far-end busy state |
| ack_pending | output | 1 | Sent I-frame not yet acknowledged |
| vs | output | 7 | Send state variable V(S) |
| vr | output | 7 | Receive state variable V(R) |

## Verification
I-frames are sent in sequence, repeated, and while the station is locally busy. These three cases separate acceptance from the two kinds of drop, and the kind of drop is read from the response type. In extended mode, N(S) values that differ from V(R) in high bits but agree in bit 0 show that only bit 0 is compared. A run of eight accepts in each mode shows where V(R) wraps. Timer behaviour is tried once with only the far end busy, where polls must never stop, and once with an unacknowledged frame, where polls must stop after cfg_n2 and the sticky failure must follow.

// File: rtl/lapb_w1_pkg.sv
// Package: shared constants and the decoded-frame record for the
// window-one sequencer. Assumes control fields of at most two octets.
package lapb_w1_pkg;
    localparam int SEQ_W  = 7;
    localparam int CTRL_W = 16;

    typedef enum logic [1:0] {
        FK_I = 2'd0,
        FK_S = 2'd1,
        FK_U = 2'd2
    } fkind_e;

    localparam logic [1:0] ST_RR  = 2'b00;
    localparam logic [1:0] ST_RNR = 2'b01;
    localparam logic [1:0] ST_REJ = 2'b10;
    localparam logic [1:0] ST_BAD = 2'b11;

    typedef struct packed {
        fkind_e           kind;
        logic [1:0]       stype;
        logic [SEQ_W-1:0] ns;
        logic [SEQ_W-1:0] nr;
        logic             pf;
    } dec_t;
endpackage

// File: rtl/lapb_w1_decode.sv
// Module: splits a received control field into kind, S type, N(S), N(R)
// and P/F. Purely combinational. Assumes unnumbered frames always use
// a single octet.
module lapb_w1_decode
    import lapb_w1_pkg::*;
(
    input  logic              cfg_ext,
    input  logic [CTRL_W-1:0] ctrl,
    output dec_t              dec
);
    localparam int SHORT_W = 3;

    fkind_e kind;

    // classify the frame from its low bits
    always_comb begin
        if (!ctrl[0])      kind = FK_I;
        else if (!ctrl[1]) kind = FK_S;
        else               kind = FK_U;
    end

    // pick the field positions for the selected format
    always_comb begin
        dec       = '0;
        dec.kind  = kind;
        dec.stype = ctrl[3:2];
        if (cfg_ext && kind != FK_U) begin
            dec.ns = ctrl[7:1];
            dec.pf = ctrl[8];
            dec.nr = ctrl[15:9];
        end else begin
            dec.ns = {{(SEQ_W-SHORT_W){1'b0}}, ctrl[3:1]};
            dec.pf = ctrl[4];
            dec.nr = {{(SEQ_W-SHORT_W){1'b0}}, ctrl[7:5]};
        end
    end
endmodule

// File: rtl/lapb_w1_timer.sv
// Module: retry timer. Counts while run is high and restarts on any
// received frame or transmitted I-frame. Raises expire for one cycle
// each time cfg_t1 cycles elapse. Assumes cfg_t1 >= 1.
module lapb_w1_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [TMR_W-1:0] cfg_t1,
    output logic             expire
);
    logic [TMR_W-1:0] cnt;

    // expiry when the last count of the period is reached
    always_comb expire = run && !restart && (cnt == cfg_t1 - TMR_W'(1));

    // period counter
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt <= '0;
        else if (restart || !run || expire)  cnt <= '0;
        else                                 cnt <= cnt + TMR_W'(1);
    end

    AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cfg_t1 != '0 && $stable(cfg_t1)) |-> (cnt < cfg_t1)); // R9
endmodule

// File: rtl/lapb_w1_core.sv
// Module: sequence state machine. Holds V(S), V(R), the ack, busy and
// retry state. Chooses supervisory requests and drives interrupts.
// Assumes at most one frame strobe per cycle and a decoded frame.
module lapb_w1_core
    import lapb_w1_pkg::*;
#(
    parameter int RETRY_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_ext,
    input  logic [RETRY_W-1:0] cfg_n2,
    input  logic               in_valid,
    input  dec_t               dec,
    input  logic               in_info,
    input  logic               cpu_rnr,
    input  logic               cpu_reset,
    input  logic               tx_i_sent,
    input  logic               tmr_expire,
    output logic               tmr_run,
    output logic               tx_s_req,
    output logic [1:0]         tx_s_type,
    output logic [SEQ_W-1:0]   tx_s_nr,
    output logic               tx_s_cmd,
    output logic               tx_s_pf,
    output logic               rx_i_accept,
    output logic               rx_u_fwd,
    output logic               irq_remote_busy,
    output logic               irq_remote_ready,
    output logic               irq_proto_err,
    output logic               irq_link_fail,
    output logic               remote_busy,
    output logic               ack_pending,
    output logic [SEQ_W-1:0]   vs,
    output logic [SEQ_W-1:0]   vr
);
    localparam logic [SEQ_W-1:0] MASK_SHORT = SEQ_W'(7);

    logic [SEQ_W-1:0]   seq_mask, vr_inc, vs_inc;
    logic [RETRY_W-1:0] retry;
    logic is_i, is_s, is_u, s_bad, nr_chk, nr_match, ack_now, nr_bad, in_seq;

    // modulus mask and incremented counters
    always_comb begin
        seq_mask = cfg_ext ? '1 : MASK_SHORT;
        vr_inc   = (vr + SEQ_W'(1)) & seq_mask;
        vs_inc   = (vs + SEQ_W'(1)) & seq_mask;
    end

    // frame class, N(R) evaluation and sequence test (bit 0 only)
    always_comb begin
        is_i     = in_valid && dec.kind == FK_I;
        is_s     = in_valid && dec.kind == FK_S;
        is_u     = in_valid && dec.kind == FK_U;
        s_bad    = is_s && (in_info || dec.stype == ST_BAD);
        nr_chk   = is_i || (is_s && !s_bad);
        nr_match = dec.nr[0] == vs[0];
        ack_now  = nr_chk && ack_pending && nr_match;
        nr_bad   = nr_chk && !ack_pending && !nr_match;
        in_seq   = dec.ns[0] == vr[0];
    end

    // the timer runs while waiting for an ack or while the far end is busy
    always_comb tmr_run = (ack_pending || remote_busy) && !irq_link_fail;

    // link state, responses and interrupts
    always_ff @(posedge clk) begin
        if (!rst_n || cpu_reset) begin
            vs <= '0;  vr <= '0;  retry <= '0;
            ack_pending <= 1'b0;  remote_busy <= 1'b0;  irq_link_fail <= 1'b0;
            tx_s_req <= 1'b0;  tx_s_type <= ST_RR;  tx_s_nr <= '0;
            tx_s_cmd <= 1'b0;  tx_s_pf <= 1'b0;
            rx_i_accept <= 1'b0;  rx_u_fwd <= 1'b0;
            irq_remote_busy <= 1'b0;  irq_remote_ready <= 1'b0;  irq_proto_err <= 1'b0;
        end else begin
            tx_s_req <= 1'b0;  tx_s_type <= ST_RR;  tx_s_nr <= vr;
            tx_s_cmd <= 1'b0;  tx_s_pf <= 1'b0;
            rx_i_accept <= 1'b0;  rx_u_fwd <= 1'b0;
            irq_remote_busy <= 1'b0;  irq_remote_ready <= 1'b0;
            irq_proto_err <= s_bad || nr_bad;
            if (is_i) begin
                tx_s_req <= 1'b1;
                tx_s_pf  <= dec.pf;
                if (cpu_rnr) begin
                    tx_s_type <= ST_RNR;
                end else if (in_seq) begin
                    rx_i_accept <= 1'b1;
                    vr          <= vr_inc;
                    tx_s_nr     <= vr_inc;
                end
            end else if (is_u) begin
                rx_u_fwd <= 1'b1;
            end else if (is_s && !s_bad) begin
                remote_busy      <= dec.stype == ST_RNR;
                irq_remote_busy  <= dec.stype == ST_RNR && !remote_busy;
                irq_remote_ready <= dec.stype != ST_RNR && remote_busy;
            end else if (tmr_expire) begin
                if (ack_pending && retry >= cfg_n2) begin
                    irq_link_fail <= 1'b1;
                end else begin
                    tx_s_req <= 1'b1;
                    tx_s_cmd <= 1'b1;
                    tx_s_pf  <= 1'b1;
                    if (ack_pending) retry <= retry + RETRY_W'(1);
                end
            end
            if (ack_now) begin
                ack_pending <= 1'b0;
                retry       <= '0;
            end else if (tx_i_sent && !ack_pending && !irq_link_fail) begin
                vs          <= vs_inc;
                ack_pending <= 1'b1;
                retry       <= '0;
            end
        end
    end

    AST_BUSY_DROPS_I: assert property (@(posedge clk) disable iff (!rst_n)
        (is_i && cpu_rnr && !cpu_reset) |=> (!rx_i_accept && tx_s_req && tx_s_type == ST_RNR)); // R5
    AST_ACCEPT_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        rx_i_accept |-> (vr != $past(vr))); // R3
    AST_U_KEEPS_VR: assert property (@(posedge clk) disable iff (!rst_n)
        rx_u_fwd |-> (vr == $past(vr))); // R8
    AST_BUSY_EDGE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        irq_remote_busy |-> (remote_busy && !$past(remote_busy))); // R6
    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_link_fail && !cpu_reset) |=> irq_link_fail); // R11
    AST_FAIL_NO_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_link_fail && !in_valid && !cpu_reset) |=> !tx_s_req); // R11
endmodule

// File: rtl/lapb_w1_seq.sv
// Module: top of the window-one link sequencer. Wires decoder, retry
// timer and state core. Assumes frames arrive already address-matched
// and FCS-checked, at most one per cycle.
module lapb_w1_seq
    import lapb_w1_pkg::*;
#(
    parameter int TMR_W   = 16,
    parameter int RETRY_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_ext,
    input  logic [TMR_W-1:0]   cfg_t1,
    input  logic [RETRY_W-1:0] cfg_n2,
    input  logic               cpu_rnr,
    input  logic               cpu_reset,
    input  logic               rx_valid,
    input  logic [15:0]        rx_ctrl,
    input  logic               rx_info,
    input  logic               tx_i_sent,
    output logic               tx_s_req,
    output logic [1:0]         tx_s_type,
    output logic [6:0]         tx_s_nr,
    output logic               tx_s_cmd,
    output logic               tx_s_pf,
    output logic               rx_i_accept,
    output logic               rx_u_fwd,
    output logic               irq_remote_busy,
    output logic               irq_remote_ready,
    output logic               irq_proto_err,
    output logic               irq_link_fail,
    output logic               remote_busy,
    output logic               ack_pending,
    output logic [6:0]         vs,
    output logic [6:0]         vr
);
    dec_t dec;
    logic tmr_run, tmr_expire, tmr_restart;

    // any frame or transmitted I-frame restarts the timer
    always_comb tmr_restart = rx_valid || tx_i_sent;

    lapb_w1_decode u_dec (
        .cfg_ext (cfg_ext),
        .ctrl    (rx_ctrl),
        .dec     (dec)
    );

    lapb_w1_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tmr_run),
        .restart (tmr_restart),
        .cfg_t1  (cfg_t1),
        .expire  (tmr_expire)
    );

    lapb_w1_core #(.RETRY_W(RETRY_W)) u_core (
        .clk              (clk),
        .rst_n            (rst_n),
        .cfg_ext          (cfg_ext),
        .cfg_n2           (cfg_n2),
        .in_valid         (rx_valid),
        .dec              (dec),
        .in_info          (rx_info),
        .cpu_rnr          (cpu_rnr),
        .cpu_reset        (cpu_reset),
        .tx_i_sent        (tx_i_sent),
        .tmr_expire       (tmr_expire),
        .tmr_run          (tmr_run),
        .tx_s_req         (tx_s_req),
        .tx_s_type        (tx_s_type),
        .tx_s_nr          (tx_s_nr),
        .tx_s_cmd         (tx_s_cmd),
        .tx_s_pf          (tx_s_pf),
        .rx_i_accept      (rx_i_accept),
        .rx_u_fwd         (rx_u_fwd),
        .irq_remote_busy  (irq_remote_busy),
        .irq_remote_ready (irq_remote_ready),
        .irq_proto_err    (irq_proto_err),
        .irq_link_fail    (irq_link_fail),
        .remote_busy      (remote_busy),
        .ack_pending      (ack_pending),
        .vs               (vs),
        .vr               (vr)
    );
endmodule

// File: tb/lapb_w1_seq_tb_top.sv
// Bench: scoreboard for supervisory requests plus direct port checks.
module lapb_w1_seq_tb_top;
    localparam int CLK_P = 10;
    localparam int T1    = 20;

    logic clk = 1'b0, rst_n = 1'b0, cfg_ext = 1'b0, cpu_rnr = 1'b0, cpu_reset = 1'b0;
    logic rx_valid = 1'b0, rx_info = 1'b0, tx_i_sent = 1'b0;
    logic [15:0] cfg_t1 = 16'(T1);
    logic [3:0]  cfg_n2 = 4'd2;
    logic [15:0] rx_ctrl = '0;
    logic tx_s_req, tx_s_cmd, tx_s_pf, rx_i_accept, rx_u_fwd;
    logic irq_remote_busy, irq_remote_ready, irq_proto_err, irq_link_fail, remote_busy, ack_pending;
    logic [1:0] tx_s_type;
    logic [6:0] tx_s_nr, vs, vr;

    int n_checks = 0, n_errors = 0;

    typedef struct {
        logic [1:0] t;
        logic [6:0] nr;
        logic       cmd;
        logic       pf;
        string      req;
    } resp_t;
    resp_t sb_q[$];

    always #(CLK_P/2) clk = ~clk;

    lapb_w1_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_ext(cfg_ext), .cfg_t1(cfg_t1), .cfg_n2(cfg_n2),
        .cpu_rnr(cpu_rnr), .cpu_reset(cpu_reset), .rx_valid(rx_valid), .rx_ctrl(rx_ctrl),
        .rx_info(rx_info), .tx_i_sent(tx_i_sent), .tx_s_req(tx_s_req), .tx_s_type(tx_s_type),
        .tx_s_nr(tx_s_nr), .tx_s_cmd(tx_s_cmd), .tx_s_pf(tx_s_pf), .rx_i_accept(rx_i_accept),
        .rx_u_fwd(rx_u_fwd), .irq_remote_busy(irq_remote_busy), .irq_remote_ready(irq_remote_ready),
        .irq_proto_err(irq_proto_err), .irq_link_fail(irq_link_fail), .remote_busy(remote_busy),
        .ack_pending(ack_pending), .vs(vs), .vr(vr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic expect_s(input logic [1:0] t, input logic [6:0] nr, input logic cmd,
                            input logic pf, input string req);
        resp_t r;
        r.t = t; r.nr = nr; r.cmd = cmd; r.pf = pf; r.req = req;
        sb_q.push_back(r);
    endtask

    // monitor: pop and compare each supervisory request
    always @(negedge clk) begin
        if (rst_n && tx_s_req) begin
            n_checks++;
            if (sb_q.size() == 0) begin
                n_errors++;
                $display("FAIL unexpected request: actual type %0d nr %0d cmd %0b expected none",
                         tx_s_type, tx_s_nr, tx_s_cmd);
            end else begin
                resp_t e;
                e = sb_q.pop_front();
                if ({tx_s_type, tx_s_nr, tx_s_cmd, tx_s_pf} !== {e.t, e.nr, e.cmd, e.pf}) begin
                    n_errors++;
                    $display("FAIL %s: actual t%0d nr%0d c%0b p%0b expected t%0d nr%0d c%0b p%0b",
                             e.req, tx_s_type, tx_s_nr, tx_s_cmd, tx_s_pf, e.t, e.nr, e.cmd, e.pf);
                end
            end
        end
    end

    task automatic send(input logic [15:0] c, input logic info);
        @(negedge clk); rx_ctrl = c; rx_valid = 1'b1; rx_info = info;
        @(negedge clk); rx_valid = 1'b0; rx_info = 1'b0;
    endtask

    task automatic pulse_sent();
        @(negedge clk); tx_i_sent = 1'b1;
        @(negedge clk); tx_i_sent = 1'b0;
    endtask

    task automatic pulse_reset();
        @(negedge clk); cpu_reset = 1'b1;
        @(negedge clk); cpu_reset = 1'b0;
    endtask

    function automatic logic [15:0] fi(input int ns, input int nr, input logic p);
        fi = {8'h00, 3'(nr), p, 3'(ns), 1'b0};
    endfunction
    function automatic logic [15:0] fs(input logic [1:0] t, input int nr);
        fs = {8'h00, 3'(nr), 1'b0, t, 2'b01};
    endfunction
    function automatic logic [15:0] fix(input int ns, input int nr, input logic p);
        fix = {7'(nr), p, 7'(ns), 1'b0};
    endfunction

    task automatic wait_q_empty(input string req);
        chk(req, 32'(sb_q.size()), 0);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R12)
        chk("R12 vs after reset", 32'(vs), 0);
        chk("R12 vr after reset", 32'(vr), 0);
        chk("R12 link fail after reset", 32'(irq_link_fail), 0);
        chk("R10 ack_pending after reset", 32'(ack_pending), 0);

        // R3 in-sequence I-frame
        expect_s(2'b00, 7'd1, 1'b0, 1'b0, "R3");
        send(fi(0, 0, 1'b0), 1'b1);
        chk("R3 accept", 32'(rx_i_accept), 1);
        chk("R3 vr", 32'(vr), 1);

        // R4 duplicate I-frame
        expect_s(2'b00, 7'd1, 1'b0, 1'b0, "R4");
        send(fi(0, 0, 1'b0), 1'b1);
        chk("R4 no accept", 32'(rx_i_accept), 0);
        chk("R4 vr held", 32'(vr), 1);

        // R5 local busy
        cpu_rnr = 1'b1;
        expect_s(2'b01, 7'd1, 1'b0, 1'b0, "R5");
        send(fi(1, 0, 1'b0), 1'b1);
        chk("R5 no accept", 32'(rx_i_accept), 0);
        chk("R5 vr held", 32'(vr), 1);
        cpu_rnr = 1'b0;

        // R3 with P set: F echoed
        expect_s(2'b00, 7'd2, 1'b0, 1'b1, "R3");
        send(fi(1, 0, 1'b1), 1'b1);
        chk("R3 vr second", 32'(vr), 2);

        // R6 remote busy, then R9 unlimited polling
        send(fs(2'b01, 0), 1'b0);
        chk("R6 irq busy", 32'(irq_remote_busy), 1);
        chk("R6 busy level", 32'(remote_busy), 1);
        for (int k = 0; k < 3; k++) expect_s(2'b00, 7'd2, 1'b1, 1'b1, "R9");
        repeat (3 * T1 + 5) @(negedge clk);
        wait_q_empty("R9 three polls");
        chk("R9 no link fail", 32'(irq_link_fail), 0);
        send(fs(2'b00, 0), 1'b0);
        chk("R6 irq ready", 32'(irq_remote_ready), 1);
        chk("R6 busy cleared", 32'(remote_busy), 0);
        repeat (2 * T1) @(negedge clk);
        wait_q_empty("R9 polling stops");

        // R7 S-frame with info field and invalid type
        send(fs(2'b00, 0), 1'b1);
        chk("R7 S with info", 32'(irq_proto_err), 1);
        send(fs(2'b11, 0), 1'b0);
        chk("R7 S type 11", 32'(irq_proto_err), 1);

        // R8 U-frame
        send(16'h002F, 1'b1);
        chk("R8 forward", 32'(rx_u_fwd), 1);
        chk("R8 vr held", 32'(vr), 2);
        chk("R8 no error", 32'(irq_proto_err), 0);

        // R10 transmit and acknowledge
        pulse_sent();
        chk("R10 vs", 32'(vs), 1);
        chk("R10 pending", 32'(ack_pending), 1);
        send(fs(2'b00, 1), 1'b0);
        chk("R10 acked", 32'(ack_pending), 0);
        chk("R10 no error", 32'(irq_proto_err), 0);

        // R7 unacceptable N(R)
        send(fs(2'b00, 0), 1'b0);
        chk("R7 bad nr", 32'(irq_proto_err), 1);

        // R11 retries then link failure
        pulse_sent();
        chk("R11 vs", 32'(vs), 2);
        for (int k = 0; k < 2; k++) expect_s(2'b00, 7'd2, 1'b1, 1'b1, "R11");
        repeat (3 * T1 + 10) @(negedge clk);
        wait_q_empty("R11 poll count");
        chk("R11 link fail", 32'(irq_link_fail), 1);
        repeat (2 * T1) @(negedge clk);
        chk("R11 sticky", 32'(irq_link_fail), 1);

        // R12 reset command
        pulse_reset();
        chk("R12 vs cleared", 32'(vs), 0);
        chk("R12 vr cleared", 32'(vr), 0);
        chk("R12 fail cleared", 32'(irq_link_fail), 0);
        chk("R12 pending cleared", 32'(ack_pending), 0);

        // R1 normal-mode wrap
        for (int k = 0; k < 8; k++) begin
            expect_s(2'b00, 7'((k + 1) % 8), 1'b0, 1'b0, "R1");
            send(fi(k, 0, 1'b0), 1'b1);
        end
        chk("R1 wrap to 0", 32'(vr), 0);

        // R1 extended mode: no wrap at 8
        cfg_ext = 1'b1;
        for (int k = 0; k < 8; k++) begin
            expect_s(2'b00, 7'(k + 1), 1'b0, 1'b0, "R1");
            send(fix(k, 0, 1'b0), 1'b1);
        end
        chk("R1 extended count", 32'(vr), 8);

        // R2 bit-0 compare only
        expect_s(2'b00, 7'd9, 1'b0, 1'b0, "R2");
        send(fix(10, 0, 1'b0), 1'b1);
        chk("R2 accepted on bit 0", 32'(rx_i_accept), 1);
        expect_s(2'b00, 7'd9, 1'b0, 1'b0, "R2");
        send(fix(8, 0, 1'b0), 1'b1);
        chk("R2 dropped on bit 0", 32'(rx_i_accept), 0);
        chk("R2 vr", 32'(vr), 9);

        repeat (4) @(negedge clk);
        wait_q_empty("scoreboard drained");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule